// File: doc/BRIEF.md
# VGA Access SMI Event Controller

This block watches a decoded stream of accesses to a legacy VGA register file and turns selected accesses into system-management interrupts. A single-cycle access strobe carries a direction and a 3-bit group code. Accesses to groups that own a status flag latch that flag and fire the synchronous SMI. Accesses to groups that own only a mask bit fire the synchronous SMI only while their mask bit is 0.

Two vertical-blank inputs and a resolution-change detector feed the asynchronous SMI path instead. A vertical-blank rising edge latches a sticky flag, and the asynchronous SMI level follows those flags until software clears them. A resolution change is checked on each frame strobe. It raises the asynchronous SMI for one cycle, but only when the timing engine is enabled, scaling is enabled, the event is not masked, and the horizontal or vertical resolution differs from the previous frame.

Software sees one 64-bit register through a plain write strobe and a combinational read bus. The upper word holds the write-one-to-clear status flags and the lower word holds the mask bits.

Top module: `vga_smi_ctrl`

## Requirements
- R1: An access sets its status flag at the clock edge where the strobe is sampled. The group codes are 0 sequencer, 1 CRTC, 2 graphics, 3 attribute, 4 DAC, 5 misc-output, 6 input-status-0 and 7 input-status-1. The flags are: sequencer read at bit 40, sequencer write at 39, CRTC read at 38, CRTC write at 37, and any CRTC access flagged invalid at 36 (an invalid access sets neither 38 nor 37). Input-status-0 read sets bit 34 and misc-output write sets bit 33.
- R2: Status bits 40:32 are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. When a set and a clear hit the same bit in the same cycle, the set wins.
- R3: `smi_sync` is high for exactly the one cycle after each edge that samples a flag-setting access from R1, and low otherwise unless R4 applies.
- R4: Seven sources fire `smi_sync` only while their mask bit is 0: input-status-1 read (bit 16), misc-output read (15), DAC read (14), DAC write (13), attribute read (12), attribute write (11) and graphics read (10). These sources set no status bit. The mask bits are read/write.
- R5: A rising edge on `vga_vblank` sets bit 35 and a rising edge on `dc_vblank` sets bit 32. `smi_async` stays high while either bit is set and falls only after both have been cleared by writes of 1.
- R6: On a `frame_start` cycle, if a previous resolution has been captured, `tgen_en` and `scale_en` are both 1, mask bit 28 is 0, and `hres` or `vres` differs from the captured values, then `smi_async` is high for the next cycle. Every `frame_start` captures the current resolution. The first `frame_start` after reset only captures.
- R7: Bits 63:41, 31:29, 27:17 and 9:0 always read 0, and writes to them have no effect.
- R8: Reset clears all status bits, all mask bits, `smi_sync` and `smi_async`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_group | input | 3 | Register group code (see R1) |
| acc_crtc_bad | input | 1 | CRTC access targets an invalid index |
| vga_vblank | input | 1 | VGA vertical-blank level |
| dc_vblank | input | 1 | Display vertical-blank level |
| tgen_en | input | 1 | VGA timing engine enabled |
| scale_en | input | 1 | Scaling enabled |
| frame_start | input | 1 | Per-frame resolution sample strobe |
| hres | input | RES_W | Current horizontal resolution |
| vres | input | RES_W | Current vertical resolution |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| smi_sync | output | 1 | Synchronous SMI pulse |
| smi_async | output | 1 | Asynchronous SMI level |

## Verification
A wrongly set or lost status flag appears on `reg_rdata` in the cycle right after the sampling edge. A flag that ought to be set but is missing also shows on `smi_async` at once when it is a vertical-blank flag. A wrong mask bit or a bad group decode shows on `smi_sync` only when the matching access arrives, one cycle after that access. Stale captured resolution values stay hidden until a later `frame_start` with both enables set gives a wrong `smi_async` pulse. The random mix therefore keeps frame strobes, enables and resolution changes frequent.

// File: rtl/vga_smi_ctrl.sv
module vga_smi_ctrl #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [2:0]       acc_group,
  input  logic             acc_crtc_bad,
  input  logic             vga_vblank,
  input  logic             dc_vblank,
  input  logic             tgen_en,
  input  logic             scale_en,
  input  logic             frame_start,
  input  logic [RES_W-1:0] hres,
  input  logic [RES_W-1:0] vres,
  input  logic             reg_wr,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  output logic             smi_sync,
  output logic             smi_async
);
  localparam int ST_LO = 32;
  localparam int ST_HI = 40;
  localparam int ST_N  = ST_HI - ST_LO + 1;
  localparam int MK_N  = 7;
  localparam int MK_LO = 10;
  localparam int RES_MK = 28;

  logic [ST_N-1:0]  st;
  logic [MK_N:0]    msk;
  logic             vga_vb_q, dc_vb_q;
  logic [RES_W-1:0] h_q, v_q;
  logic             res_seen, sync_q, res_q;

  logic rd, wr;
  assign rd = acc_valid & ~acc_write;
  assign wr = acc_valid &  acc_write;

  logic g_seq, g_crtc, g_gfx, g_attr, g_dac, g_misc, g_isr0, g_isr1;
  assign g_seq  = acc_group == 3'd0;
  assign g_crtc = acc_group == 3'd1;
  assign g_gfx  = acc_group == 3'd2;
  assign g_attr = acc_group == 3'd3;
  assign g_dac  = acc_group == 3'd4;
  assign g_misc = acc_group == 3'd5;
  assign g_isr0 = acc_group == 3'd6;
  assign g_isr1 = acc_group == 3'd7;

  logic [ST_N-1:0] st_set;
  assign st_set = {
    rd & g_seq,
    wr & g_seq,
    rd & g_crtc & ~acc_crtc_bad,
    wr & g_crtc & ~acc_crtc_bad,
    acc_valid & g_crtc & acc_crtc_bad,
    vga_vblank & ~vga_vb_q,
    rd & g_isr0,
    wr & g_misc,
    dc_vblank & ~dc_vb_q
  };

  logic [MK_N-1:0] mk_ev;
  assign mk_ev = {rd & g_isr1, rd & g_misc, rd & g_dac, wr & g_dac,
                  rd & g_attr, wr & g_attr, rd & g_gfx};

  logic sync_hit;
  assign sync_hit = (|st_set[8:4]) | (|st_set[2:1]) | (|(mk_ev & ~msk[MK_N-1:0]));

  logic res_diff, res_hit;
  assign res_diff = (hres != h_q) | (vres != v_q);
  assign res_hit  = frame_start & res_seen & tgen_en & scale_en & ~msk[MK_N] & res_diff;

  logic [ST_N-1:0] st_clr;
  assign st_clr = reg_wr ? reg_wdata[ST_HI:ST_LO] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= '0;
      msk      <= '0;
      vga_vb_q <= 1'b0;
      dc_vb_q  <= 1'b0;
      h_q      <= '0;
      v_q      <= '0;
      res_seen <= 1'b0;
      sync_q   <= 1'b0;
      res_q    <= 1'b0;
    end else begin
      st       <= (st & ~st_clr) | st_set;
      if (reg_wr)
        msk <= {reg_wdata[RES_MK], reg_wdata[MK_LO+MK_N-1:MK_LO]};
      vga_vb_q <= vga_vblank;
      dc_vb_q  <= dc_vblank;
      sync_q   <= sync_hit;
      res_q    <= res_hit;
      if (frame_start) begin
        h_q      <= hres;
        v_q      <= vres;
        res_seen <= 1'b1;
      end
    end
  end

  assign smi_sync  = sync_q;
  assign smi_async = st[3] | st[0] | res_q;
  assign reg_rdata = {23'd0, st, 3'd0, msk[MK_N], 11'd0, msk[MK_N-1:0], 10'd0};

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[63:41], reg_wdata[31:29], reg_wdata[27:17], reg_wdata[9:0]};
endmodule

// File: rtl/vga_smi_chk.sv
module vga_smi_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_seq_rd,
  input logic        clr40,
  input logic        clr35,
  input logic        vb_rise,
  input logic        acc_valid,
  input logic [63:0] reg_rdata,
  input logic        smi_sync,
  input logic        smi_async
);
  a_r3_sync_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    smi_sync |-> $past(acc_valid));

  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr40 && !acc_seq_rd) |=> !reg_rdata[40]);

  a_r5_vblank_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[35] && !clr35) |=> reg_rdata[35]);

  a_r5_vblank_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    vb_rise |=> reg_rdata[35]);

  a_r5_async_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[35] || reg_rdata[32]) |-> smi_async);

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[63:41] == 23'd0) && (reg_rdata[31:29] == 3'd0) &&
    (reg_rdata[27:17] == 11'd0) && (reg_rdata[9:0] == 10'd0));
endmodule

bind vga_smi_ctrl vga_smi_chk i_vga_smi_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_seq_rd(acc_valid & ~acc_write & (acc_group == 3'd0)),
  .clr40     (reg_wr & reg_wdata[40]),
  .clr35     (reg_wr & reg_wdata[35]),
  .vb_rise   (vga_vblank & ~vga_vb_q),
  .acc_valid (acc_valid),
  .reg_rdata (reg_rdata),
  .smi_sync  (smi_sync),
  .smi_async (smi_async)
);

// File: tb/test_vga_smi_ctrl.sv
`timescale 1ns/1ps
module test_vga_smi_ctrl;
  localparam int RW = 12;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_crtc_bad = 0;
  logic [2:0] acc_group = 0;
  logic vga_vblank = 0, dc_vblank = 0, tgen_en = 0, scale_en = 0, frame_start = 0;
  logic [RW-1:0] hres = 0, vres = 0;
  logic reg_wr = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic smi_sync, smi_async;

  vga_smi_ctrl #(.RES_W(RW)) i_vga_smi_ctrl (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [8:0] m_st = 0;
  logic [7:0] m_mk = 0;
  logic m_vq = 0, m_dq = 0, m_seen = 0, m_sync = 0, m_res = 0;
  logic [RW-1:0] m_h = 0, m_v = 0;

  function automatic logic [63:0] exp_rd();
    return {23'd0, m_st, 3'd0, m_mk[7], 11'd0, m_mk[6:0], 10'd0};
  endfunction

  task automatic model_step();
    logic rd, wr;
    logic [8:0] set;
    logic [6:0] ev;
    rd = acc_valid & ~acc_write;
    wr = acc_valid & acc_write;
    set = 0;
    if (acc_group == 0) begin set[8] = rd; set[7] = wr; end
    if (acc_group == 1) begin
      if (acc_crtc_bad) set[4] = acc_valid;
      else begin set[6] = rd; set[5] = wr; end
    end
    set[3] = vga_vblank & ~m_vq;
    set[2] = rd & (acc_group == 6);
    set[1] = wr & (acc_group == 5);
    set[0] = dc_vblank & ~m_dq;
    ev = 0;
    ev[6] = rd & (acc_group == 7);
    ev[5] = rd & (acc_group == 5);
    ev[4] = rd & (acc_group == 4);
    ev[3] = wr & (acc_group == 4);
    ev[2] = rd & (acc_group == 3);
    ev[1] = wr & (acc_group == 3);
    ev[0] = rd & (acc_group == 2);
    m_sync = (|set[8:4]) | (|set[2:1]) | (|(ev & ~m_mk[6:0]));
    m_res = frame_start & m_seen & tgen_en & scale_en & ~m_mk[7] & ((hres != m_h) | (vres != m_v));
    if (frame_start) begin m_h = hres; m_v = vres; m_seen = 1; end
    m_st = (m_st & ~(reg_wr ? reg_wdata[40:32] : 9'd0)) | set;
    if (reg_wr) m_mk = {reg_wdata[28], reg_wdata[16:10]};
    m_vq = vga_vblank;
    m_dq = dc_vblank;
  endtask

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_write = 0; acc_group = 0; acc_crtc_bad = 0;
    frame_start = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk); #1;
    check(tag, "reg_rdata", reg_rdata, exp_rd());
    check(tag, "smi_sync", {63'd0, smi_sync}, {63'd0, m_sync});
    check(tag, "smi_async", {63'd0, smi_async}, {63'd0, m_st[3] | m_st[0] | m_res});
    @(negedge clk);
    idle();
  endtask

  task automatic acc(string tag, logic w, logic [2:0] g, logic bad);
    acc_valid = 1; acc_write = w; acc_group = g; acc_crtc_bad = bad;
    step(tag);
  endtask

  task automatic regw(string tag, logic [63:0] d);
    reg_wr = 1; reg_wdata = d;
    step(tag);
  endtask

  task automatic frame(string tag, logic [RW-1:0] h, logic [RW-1:0] v);
    frame_start = 1; hres = h; vres = v;
    step(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8", "reg_rdata", reg_rdata, 64'd0);
    check("R8", "smi_sync", {63'd0, smi_sync}, 64'd0);
    check("R8", "smi_async", {63'd0, smi_async}, 64'd0);
    @(negedge clk);
    rst_n = 1;

    // R1 / R3: each flag-bearing access, then idle cycle to see the pulse end
    acc("R1", 0, 0, 0); step("R3");
    acc("R1", 1, 0, 0);
    acc("R1", 0, 1, 0);
    acc("R1", 1, 1, 0);
    acc("R1", 1, 1, 1);
    acc("R1", 0, 6, 0);
    acc("R1", 1, 5, 0);
    acc("R3", 1, 6, 0); step("R3");
    check("R1", "status", reg_rdata, 64'h0000_01F6_0000_0000);

    // R2: write 0 no effect, write 1 clears, set wins over clear
    regw("R2", 64'd0);
    regw("R2", 64'h0000_0100_0000_0000);
    acc_valid = 1; acc_write = 0; acc_group = 0; reg_wr = 1; reg_wdata = 64'h0000_0100_0000_0000;
    step("R2");
    regw("R2", 64'h0000_01FF_0000_0000);

    // R4: masked sources
    for (int g = 2; g < 8; g++) begin acc("R4", 0, 3'(g), 0); acc("R4", 1, 3'(g), 0); end
    regw("R4", 64'h0000_0000_0001_FC00);
    for (int g = 2; g < 8; g++) begin acc("R4", 0, 3'(g), 0); acc("R4", 1, 3'(g), 0); end
    regw("R4", 64'h0000_0000_0000_4000);
    acc("R4", 0, 4, 0); acc("R4", 1, 4, 0); acc("R4", 0, 7, 0);
    regw("R4", 64'd0);

    // R5: vblank flags
    vga_vblank = 1; step("R5"); step("R5"); vga_vblank = 0; step("R5");
    dc_vblank = 1; step("R5"); dc_vblank = 0;
    regw("R5", 64'h0000_0008_0000_0000); step("R5");
    regw("R5", 64'h0000_0001_0000_0000); step("R5");

    // R6: resolution change
    tgen_en = 1; scale_en = 1;
    frame("R6", 640, 480); step("R6");
    frame("R6", 640, 480);
    frame("R6", 720, 480); step("R6");
    frame("R6", 720, 400);
    regw("R6", 64'h0000_0000_1000_0000);
    frame("R6", 800, 600);
    regw("R6", 64'd0);
    tgen_en = 0; frame("R6", 640, 480);
    tgen_en = 1; scale_en = 0; frame("R6", 800, 600);
    scale_en = 1; frame("R6", 800, 601);

    // R7: reserved bits
    regw("R7", '1);
    regw("R7", 64'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      acc_valid = r < 60; acc_write = $urandom_range(0, 1);
      acc_group = 3'($urandom_range(0, 7)); acc_crtc_bad = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 9) == 0) vga_vblank = ~vga_vblank;
      if ($urandom_range(0, 9) == 0) dc_vblank = ~dc_vblank;
      tgen_en = $urandom_range(0, 5) != 0; scale_en = $urandom_range(0, 5) != 0;
      frame_start = $urandom_range(0, 3) == 0;
      hres = $urandom_range(0, 2) == 0 ? RW'($urandom_range(0, 3)) : hres;
      vres = $urandom_range(0, 3) == 0 ? RW'($urandom_range(0, 3)) : vres;
      reg_wr = $urandom_range(0, 7) == 0;
      reg_wdata = {$urandom, $urandom};
      step("RND");
    end
    finish_run();
  end

  initial void'($urandom(32'h5EED_1234));
endmodule